// File: doc/BRIEF.md
# Gain-Ranging Converter Input Port

This block receives samples from a gain-ranging or floating-point analog-to-digital converter and turns each one into a normalized 23-bit fixed-point word for the mixer that follows. Each sample arrives as a 16-bit two's-complement mantissa, a 3-bit exponent and a channel-select bit. Each sample is qualified by a strobe. Two exponent controls adapt the port to converters with different gain conventions. One control inverts the exponent polarity, and the other subtracts an offset from the exponent. A bypass mode ignores the exponent completely and treats the mantissa as plain fixed-point data.

The port works in one of three modes. In single real mode every sample is emitted on its own. In single complex mode the select bit marks the I half and the Q half of a pair. In diversity mode the select bit marks interleaved samples of two independent real channels, channel A and channel B. In both paired modes the two halves are emitted together on two output streams, so the two streams keep the same timing. A sample that breaks the expected alternation of the select bit is dropped, and the event is recorded in a sticky error flag.

Top module: `fpadc_inport`

## Requirements
- R1: After reset, `out0_valid`, `out1_valid` and `seq_err` are 0 and both data outputs are 0. The first sample expected in a paired mode is the one with `in_ab`=1.
- R2: The shift amount is derived from an effective exponent e. e equals `in_exp` when `cfg_exp_inv`=0 and equals the bitwise inverse of `in_exp` when `cfg_exp_inv`=1. The shift s equals e minus `cfg_exp_off` when e is greater than `cfg_exp_off`, and 0 otherwise. The output word is {mantissa, 7 zero bits} as a 23-bit signed value, shifted right arithmetically by s.
- R3: When `cfg_fixed`=1, the output word is {mantissa, 7 zero bits}, whatever the values of the exponent, the inversion control and the offset.
- R4: In real mode (`cfg_mode`=0, and also the reserved code 3), every strobed sample appears on `out0_data` with `out0_valid` high one clock later. `out1_valid` stays low, and `in_ab` has no effect.
- R5: In complex mode (`cfg_mode`=1), a sample with `in_ab`=1 is held as the I half and produces no output. The next sample, with `in_ab`=0, is the Q half. One clock after the Q half, `out0_valid` and `out1_valid` are both high, with I on `out0_data` and Q on `out1_data`.
- R6: In diversity mode (`cfg_mode`=2), a sample with `in_ab`=1 belongs to channel A and a sample with `in_ab`=0 belongs to channel B. Both samples leave together, one clock after the B sample: channel A on `out0_data` and channel B on `out1_data`, with both valids high.
- R7: In a paired mode, a strobed sample whose `in_ab` is not the expected value is dropped. It produces no output, leaves the expected value unchanged, and sets `seq_err`. `seq_err` stays set until reset.
- R8: In a cycle that follows no emitted result, both valids are low and both data outputs keep their previous values.
- R9: While the mode is real, the pairing state returns to expecting `in_ab`=1. Any held half is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_mant | input | 16 | Two's-complement mantissa |
| in_exp | input | 3 | Converter exponent |
| in_ab | input | 1 | Channel / half select |
| cfg_mode | input | 2 | 0 real, 1 complex, 2 diversity, 3 treated as real |
| cfg_fixed | input | 1 | Bypass the exponent path |
| cfg_exp_inv | input | 1 | Invert the exponent polarity |
| cfg_exp_off | input | 3 | Offset subtracted from the exponent |
| out0_valid | output | 1 | Stream 0 result strobe |
| out0_data | output | 23 | Real sample, I half, or channel A |
| out1_valid | output | 1 | Stream 1 result strobe |
| out1_data | output | 23 | Q half or channel B |
| seq_err | output | 1 | Sticky alternation error |

## Verification
Each result is due exactly one rising edge after the strobed sample that completes it. For a real sample, that sample is the one just strobed. For a pair, it is the second half, and the first half yields nothing on that edge. The sticky error also appears one edge after the offending sample. The bench drives each sample on a falling edge, waits for the next rising edge, and compares all outputs a little later against a bench model advanced by exactly one step. In this way, every comparison falls in the cycle where the result is due and in the quiet cycles between results.

// File: rtl/fpin_pkg.sv
package fpin_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_CPLX = 2'd1,
    MODE_DIV  = 2'd2,
    MODE_RSVD = 2'd3
  } in_mode_e;

  function automatic logic mode_is_paired(in_mode_e m);
    return (m == MODE_CPLX) || (m == MODE_DIV);
  endfunction
endpackage

// File: rtl/fpin_norm.sv
module fpin_norm #(
  parameter int MANT_W = 16,
  parameter int EXP_W  = 3,
  localparam int PAD_W = (1 << EXP_W) - 1,
  localparam int OUT_W = MANT_W + PAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  input  logic              exp_inv,
  input  logic [EXP_W-1:0]  exp_off,
  input  logic              fixed,
  output logic [OUT_W-1:0]  word
);
  function automatic logic [EXP_W-1:0] shift_amt(logic [EXP_W-1:0] x,
                                                 logic inv,
                                                 logic [EXP_W-1:0] off);
    logic [EXP_W-1:0] eff;
    eff = inv ? ~x : x;
    return (eff > off) ? (eff - off) : '0;
  endfunction

  function automatic logic [OUT_W-1:0] place(logic [MANT_W-1:0] m,
                                             logic [EXP_W-1:0] sh);
    logic signed [OUT_W-1:0] w;
    w = $signed({m, {PAD_W{1'b0}}});
    return w >>> sh;
  endfunction

  logic [EXP_W-1:0] sh_w;
  assign sh_w = fixed ? '0 : shift_amt(expo, exp_inv, exp_off);
  assign word = place(mant, sh_w);

  // R2
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word[OUT_W-1] == mant[MANT_W-1]);
  // R3
  fixed_noshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fixed |-> (sh_w == '0));
endmodule

// File: rtl/fpin_seq.sv
module fpin_seq
  import fpin_pkg::*;
#(
  parameter int OUT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             ab,
  input  in_mode_e         mode,
  input  logic [OUT_W-1:0] word,
  output logic             o0_valid,
  output logic [OUT_W-1:0] o0_data,
  output logic             o1_valid,
  output logic [OUT_W-1:0] o1_data,
  output logic             err
);
  logic             want_first;
  logic [OUT_W-1:0] held;
  logic             paired;
  logic             ev_real, ev_first, ev_second, ev_bad;

  assign paired    = mode_is_paired(mode);
  assign ev_real   = valid && !paired;
  assign ev_bad    = valid && paired && (ab != want_first);
  assign ev_first  = valid && paired && ab && want_first;
  assign ev_second = valid && paired && !ab && !want_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_first <= 1'b1;
      held       <= '0;
      o0_valid   <= 1'b0;
      o1_valid   <= 1'b0;
      o0_data    <= '0;
      o1_data    <= '0;
      err        <= 1'b0;
    end else begin
      o0_valid <= ev_real || ev_second;
      o1_valid <= ev_second;
      if (ev_real)        o0_data <= word;
      else if (ev_second) o0_data <= held;
      if (ev_second)      o1_data <= word;
      if (ev_first)       held    <= word;
      if (!paired)        want_first <= 1'b1;
      else if (ev_first)  want_first <= 1'b0;
      else if (ev_second) want_first <= 1'b1;
      if (ev_bad)         err <= 1'b1;
    end
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R7
  drop_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> (err && !o0_valid && !o1_valid));
  // R5
  pair_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o1_valid |-> o0_valid);
  // R4
  real_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_real |=> (o0_valid && !o1_valid));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_real || ev_second) |=> (!o0_valid && $stable(o0_data) && $stable(o1_data)));
endmodule

// File: rtl/fpadc_inport.sv
module fpadc_inport
  import fpin_pkg::*;
#(
  parameter int MANT_W = 16,
  parameter int EXP_W  = 3,
  localparam int OUT_W = MANT_W + (1 << EXP_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MANT_W-1:0] in_mant,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic              in_ab,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_fixed,
  input  logic              cfg_exp_inv,
  input  logic [EXP_W-1:0]  cfg_exp_off,
  output logic              out0_valid,
  output logic [OUT_W-1:0]  out0_data,
  output logic              out1_valid,
  output logic [OUT_W-1:0]  out1_data,
  output logic              seq_err
);
  logic [OUT_W-1:0] norm_word;

  fpin_norm #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_norm (
    .clk     (clk),
    .rst_n   (rst_n),
    .mant    (in_mant),
    .expo    (in_exp),
    .exp_inv (cfg_exp_inv),
    .exp_off (cfg_exp_off),
    .fixed   (cfg_fixed),
    .word    (norm_word)
  );

  fpin_seq #(.OUT_W(OUT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (in_valid),
    .ab       (in_ab),
    .mode     (in_mode_e'(cfg_mode)),
    .word     (norm_word),
    .o0_valid (out0_valid),
    .o0_data  (out0_data),
    .o1_valid (out1_valid),
    .o1_data  (out1_data),
    .err      (seq_err)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!out0_valid && !out1_valid && !seq_err));
endmodule

// File: tb/fpadc_inport_bench.sv
module fpadc_inport_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [15:0] in_mant = 0;
  logic [2:0]  in_exp = 0;
  logic        in_ab = 0;
  logic [1:0]  cfg_mode = 0;
  logic        cfg_fixed = 0;
  logic        cfg_exp_inv = 0;
  logic [2:0]  cfg_exp_off = 0;
  logic        out0_valid, out1_valid, seq_err;
  logic [22:0] out0_data, out1_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model state
  bit          m_first = 1;
  bit          m_err = 0;
  bit          m_v0 = 0, m_v1 = 0;
  logic [22:0] m_held = 0, m_d0 = 0, m_d1 = 0;

  always #4 clk = ~clk;

  fpadc_inport u_fpadc_inport (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
    .in_exp(in_exp), .in_ab(in_ab), .cfg_mode(cfg_mode), .cfg_fixed(cfg_fixed),
    .cfg_exp_inv(cfg_exp_inv), .cfg_exp_off(cfg_exp_off),
    .out0_valid(out0_valid), .out0_data(out0_data),
    .out1_valid(out1_valid), .out1_data(out1_data), .seq_err(seq_err)
  );

  function automatic logic [22:0] ref_norm(logic [15:0] m, logic [2:0] e,
                                           bit inv, logic [2:0] off, bit fx);
    longint v;
    int ee, s;
    v = longint'($signed(m)) * 128;
    if (fx) return v[22:0];
    ee = inv ? (7 - int'(e)) : int'(e);
    s  = (ee > int'(off)) ? ee - int'(off) : 0;
    v  = v >>> s;
    return v[22:0];
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic model_reset();
    m_first = 1; m_err = 0; m_v0 = 0; m_v1 = 0;
    m_held = 0; m_d0 = 0; m_d1 = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    @(posedge clk); @(posedge clk);
    #1;
    model_reset();
    chk(out0_valid == 0 && out1_valid == 0, "R1 valids", {out0_valid, out1_valid}, 0);
    chk(out0_data == 0 && out1_data == 0, "R1 data", out0_data | out1_data, 0);
    chk(seq_err == 0, "R1 seq_err", seq_err, 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step(bit v, bit ab, logic [15:0] m, logic [2:0] e);
    bit paired, er, ef, es, ev;
    logic [22:0] w;
    string mt;
    @(negedge clk);
    in_valid = v; in_ab = ab; in_mant = m; in_exp = e;
    paired = (cfg_mode == 2'd1) || (cfg_mode == 2'd2);
    w  = ref_norm(m, e, cfg_exp_inv, cfg_exp_off, cfg_fixed);
    ev = v && !paired;
    er = v && paired && (ab != m_first);
    ef = v && paired && ab && m_first;
    es = v && paired && !ab && !m_first;
    m_v0 = ev || es;
    m_v1 = es;
    if (ev) m_d0 = w; else if (es) m_d0 = m_held;
    if (es) m_d1 = w;
    if (ef) m_held = w;
    if (!paired) m_first = 1; else if (ef) m_first = 0; else if (es) m_first = 1;
    if (er) m_err = 1;
    mt = (cfg_mode == 2'd1) ? "R5" : (cfg_mode == 2'd2) ? "R6" : "R4";
    @(posedge clk);
    #1;
    in_valid = 0;
    chk(out0_valid == m_v0, {mt, " out0_valid"}, out0_valid, m_v0);
    chk(out1_valid == m_v1, {mt, " out1_valid"}, out1_valid, m_v1);
    chk(out0_data == m_d0, m_v0 ? (cfg_fixed ? "R3 out0_data" : "R2 out0_data") : "R8 out0_data hold",
        out0_data, m_d0);
    chk(out1_data == m_d1, m_v1 ? (cfg_fixed ? "R3 out1_data" : "R2 out1_data") : "R8 out1_data hold",
        out1_data, m_d1);
    chk(seq_err == m_err, "R7 seq_err", seq_err, m_err);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 20240611;
    void'($urandom(seed));
    do_reset();

    // R2 directed: negative full scale, shift 7
    cfg_mode = 0; cfg_fixed = 0; cfg_exp_inv = 0; cfg_exp_off = 0;
    step(1, 0, 16'h8000, 3'd7);
    chk(out0_data == 23'h7F8000, "R2 min mantissa shift 7", out0_data, 23'h7F8000);
    // R2 inverted exponent with offset: e=~3=4, s=3
    cfg_exp_inv = 1; cfg_exp_off = 3'd1;
    step(1, 1, 16'h4000, 3'd3);
    chk(out0_data == 23'h040000, "R2 inverted with offset", out0_data, 23'h040000);
    // R2 offset above exponent saturates to shift 0
    cfg_exp_inv = 0; cfg_exp_off = 3'd6;
    step(1, 0, 16'h1234, 3'd2);
    chk(out0_data == 23'h091A00, "R2 offset saturates", out0_data, 23'h091A00);
    // R3 fixed bypass
    cfg_fixed = 1; cfg_exp_off = 0;
    step(1, 0, 16'hFFFF, 3'd7);
    chk(out0_data == 23'h7FFF80, "R3 fixed bypass", out0_data, 23'h7FFF80);
    cfg_fixed = 0;
    // R4 idle then R8 hold
    step(0, 1, 16'h5555, 3'd1);

    // R5 complex pair
    cfg_mode = 1;
    step(1, 1, 16'h0100, 3'd0);
    step(1, 0, 16'h0200, 3'd0);
    chk(out0_data == 23'h008000 && out1_data == 23'h010000, "R5 I/Q order",
        {out0_data, out1_data}, {23'h008000, 23'h010000});
    // R6 diversity pair with idle gap
    cfg_mode = 2;
    step(1, 1, 16'h0300, 3'd1);
    step(0, 0, 16'h0000, 3'd0);
    step(1, 0, 16'h0400, 3'd1);
    // R9 mode to real abandons held half
    cfg_mode = 1;
    step(1, 1, 16'h0700, 3'd0);
    cfg_mode = 0;
    step(1, 0, 16'h0800, 3'd0);
    cfg_mode = 1;
    step(1, 1, 16'h0900, 3'd0);
    step(1, 0, 16'h0A00, 3'd0);
    chk(out0_data == 23'h048000, "R9 fresh pair after real", out0_data, 23'h048000);
    chk(seq_err == 0, "R9 no error", seq_err, 0);
    // R7 repeated ab drops sample
    step(1, 0, 16'h0B00, 3'd0);
    chk(seq_err == 1 && out0_valid == 0, "R7 drop and flag", {seq_err, out0_valid}, 2'b10);

    // R7 first sample after reset with ab=0
    do_reset();
    cfg_mode = 2;
    step(1, 0, 16'h0C00, 3'd0);
    chk(seq_err == 1, "R7 first sample ab low", seq_err, 1);

    // random blocks
    do_reset();
    for (int blk = 0; blk < 60; blk++) begin
      cfg_mode    = 2'($urandom_range(0, 3));
      cfg_fixed   = ($urandom_range(0, 4) == 0);
      cfg_exp_inv = 1'($urandom);
      cfg_exp_off = 3'($urandom);
      for (int k = 0; k < 40; k++) begin
        bit v, ab;
        v  = ($urandom_range(0, 3) != 0);
        ab = ($urandom_range(0, 19) == 0) ? !m_first : m_first;
        if (cfg_mode == 2'd0 || cfg_mode == 2'd3) ab = 1'($urandom);
        step(v, ab, 16'($urandom), 3'($urandom));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule